// File: doc/BRIEF.md
# Cartridge Hotspot Bank-Switching Mapper

This block connects a console CPU's 4 KiB cartridge window to a 32 KiB ROM image. A 12-bit window offset is turned into a 15-bit ROM byte address using a current-bank register. The first 0xC00 bytes of the image are a driver area that the CPU cannot reach. Six 4 KiB banks follow that area.

Software changes the bank by touching one of six hotspot offsets at the top of the window. A read or a write to a hotspot updates the bank register on the clock edge that ends the access. The access that touches the hotspot still uses the old bank, so its read data comes from the bank that was selected before the switch.

The ROM read port is synchronous. Read data therefore reaches the CPU one cycle after the read strobe, and a valid flag marks it.

Top module: `hsm_mapper`

## Requirements
- R1: An access (read or write) to window offset 0xFF6, 0xFF7, 0xFF8, 0xFF9, 0xFFA or 0xFFB selects bank 0, 1, 2, 3, 4 or 5 respectively for every later access.
- R2: After reset the current bank is 5, so a read of offset 0x000 drives ROM address 0x5C00.
- R3: During an access, `rom_addr` equals window offset + 0xC00 + bank × 0x1000, taken modulo 0x8000.
- R4: During a hotspot access, `rom_addr` still uses the bank selected before that access, so the data returned for a hotspot read comes from the old bank.
- R5: A write to a hotspot switches the bank exactly as a read does. A write never raises `cpu_rvalid`.
- R6: Reads or writes to any non-hotspot offset, including the neighbours 0xFF5 and 0xFFC, leave the bank unchanged. Idle cycles also leave it unchanged.
- R7: A read presented in cycle N has its data on `cpu_rdata`, with `cpu_rvalid` high, in cycle N+1. `rom_rd` follows `cpu_rd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 12 | Offset within the 4 KiB cartridge window |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_rvalid | output | 1 | High in the cycle after a read |
| rom_addr | output | 15 | ROM byte address |
| rom_rd | output | 1 | ROM read enable |
| rom_rdata | input | 8 | ROM data, registered inside the ROM |

## Verification
The bench walks all six hotspots in order, from the reset bank. Each hotspot read is followed by a plain read. This separates the old-bank address on the hotspot itself from the new-bank address on the next access, and it catches any mix-up in the hotspot-to-bank order.

A hotspot write followed by a read shows that writes switch banks but return no data. Reads and writes to the offsets just outside the hotspot range, and idle gaps, must leave the bank alone; this exposes an off-by-one in the hotspot decode.

Window offsets 0x000 and 0xFFF under several banks check the address sum at both ends of the window. A mid-run reset checks that the reset bank comes back.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
    localparam int WIN_AW      = 12;
    localparam int ROM_AW      = 15;
    localparam int DATA_W      = 8;
    localparam int NUM_BANKS   = 6;
    localparam int BANK_W      = $clog2(NUM_BANKS);
    localparam int RESET_BANK  = NUM_BANKS - 1;
    localparam logic [WIN_AW-1:0] HOT_FIRST = 12'hFF6;
    localparam logic [ROM_AW-1:0] BANK_BASE = 15'h0C00;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        logic rvalid;
    } rd_state_t;
endpackage

// File: rtl/hsm_hot_decode.sv
module hsm_hot_decode
    import hsm_pkg::*;
(
    input  logic [WIN_AW-1:0] addr,
    input  logic              access,
    output logic              hit,
    output bank_t             sel
);
    logic [NUM_BANKS-1:0] match;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hot
        assign match[g] = access && (addr == WIN_AW'(HOT_FIRST + WIN_AW'(g)));
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (match[i]) sel = BANK_W'(i);
        end
    end

    assign hit = |match;

    always_comb begin
        assert ($onehot0(match)) else $error("p_onehot_match_r1");
    end
endmodule

// File: rtl/hsm_bank_reg.sv
module hsm_bank_reg
    import hsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  access,
    input  logic  load,
    input  bank_t load_bank,
    output bank_t bank_q
);
    bank_t bank_d;

    always_comb begin
        bank_d = bank_q;
        if (load) bank_d = load_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= BANK_W'(RESET_BANK);
        else        bank_q <= bank_d;
    end

    p_reset_bank_r2: assert property (@(posedge clk)
        $rose(rst_n) |-> bank_q == BANK_W'(RESET_BANK));

    p_hot_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bank_q == $past(load_bank));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q));

    p_load_needs_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> access);

    p_bank_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q < BANK_W'(NUM_BANKS));
endmodule

// File: rtl/hsm_addr_map.sv
module hsm_addr_map
    import hsm_pkg::*;
(
    input  logic [WIN_AW-1:0] offset,
    input  bank_t             bank,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [ROM_AW-1:0] bank_off;

    assign bank_off = ROM_AW'(32'(bank) << WIN_AW);
    assign rom_addr = ROM_AW'(ROM_AW'(offset) + BANK_BASE + bank_off);
endmodule

// File: rtl/hsm_mapper.sv
module hsm_mapper
    import hsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rvalid,
    output logic [14:0]       rom_addr,
    output logic              rom_rd,
    input  logic [7:0]        rom_rdata
);
    logic      access;
    logic      hot_hit;
    bank_t     hot_sel;
    bank_t     bank_q;
    rd_state_t st_d, st_q;

    assign access = cpu_rd | cpu_wr;

    hsm_hot_decode u_dec (
        .addr   (cpu_addr),
        .access (access),
        .hit    (hot_hit),
        .sel    (hot_sel)
    );

    hsm_bank_reg u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .access    (access),
        .load      (hot_hit),
        .load_bank (hot_sel),
        .bank_q    (bank_q)
    );

    hsm_addr_map u_map (
        .offset   (cpu_addr),
        .bank     (bank_q),
        .rom_addr (rom_addr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = cpu_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_rd     = cpu_rd;
    assign cpu_rvalid = st_q.rvalid;
    assign cpu_rdata  = rom_rdata;

    p_rvalid_follows_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> cpu_rvalid);

    p_write_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd) |=> !cpu_rvalid);

    p_addr_in_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> rom_addr >= BANK_BASE);
endmodule

// File: tb/hsm_mapper_tb_top.sv
module hsm_mapper_tb_top;
    logic        clk = 0;
    logic        rst_n;
    logic [11:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic [14:0] rom_addr;
    logic        rom_rd;
    logic [7:0]  rom_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int model_bank;
    logic [7:0] exp_q[$];
    bit done = 0;

    always #4 clk = ~clk;

    hsm_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata)
    );

    function automatic logic [7:0] romf(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    always_ff @(posedge clk) rom_rdata <= rom_rd ? romf(rom_addr) : 8'h00;

    // monitor: R7 data and latency
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cpu_rvalid === 1'b1) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7/R5: unexpected rvalid, data %h expected none", cpu_rdata);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (cpu_rdata !== e) begin
                    n_fail++;
                    $display("FAIL R7: rdata %h expected %h", cpu_rdata, e);
                end
            end
        end
    end

    function automatic logic [14:0] exp_addr(int off, int bank);
        return 15'((off + 'hC00 + bank * 'h1000) % 'h8000);
    endfunction

    task automatic acc(input int off, input bit rd, input bit wr, input string req);
        logic [14:0] ea;
        ea = exp_addr(off, model_bank);
        @(negedge clk);
        cpu_addr = 12'(off); cpu_rd = rd; cpu_wr = wr;
        #1;
        n_tests++;
        if (rom_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: rom_addr %h expected %h (off %h)", req, rom_addr, ea, off);
        end
        if (rd) exp_q.push_back(romf(ea));
        if (off >= 'hFF6 && off <= 'hFFB) model_bank = off - 'hFF6;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cpu_rd = 0; cpu_wr = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_bank = 5;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; rst_n = 0;
        model_bank = 5;
        do_reset();
        // reset state: no valid (R7), default bank (R2)
        @(negedge clk);
        n_tests++;
        if (cpu_rvalid !== 1'b0) begin
            n_fail++; $display("FAIL R7: rvalid %b after reset expected 0", cpu_rvalid);
        end
        acc('h000, 1, 0, "R2");
        acc('hFFF, 1, 0, "R3");
        // walk hotspots: old bank on hotspot (R4), new bank after (R1)
        for (int i = 0; i < 6; i++) begin
            acc('hFF6 + i, 1, 0, "R4");
            acc('h123, 1, 0, "R1");
            acc('hFFF, 1, 0, "R3");
        end
        idle(2);
        // write to hotspot switches, no data (R5)
        acc('hFF8, 0, 1, "R5");
        idle(1);
        #1;
        n_tests++;
        if (cpu_rvalid !== 1'b0) begin
            n_fail++; $display("FAIL R5: rvalid %b after write expected 0", cpu_rvalid);
        end
        acc('h010, 1, 0, "R5");
        // non-hotspot accesses hold bank (R6)
        acc('hFF5, 1, 0, "R6");
        acc('hFFC, 1, 0, "R6");
        acc('hFF5, 0, 1, "R6");
        acc('hFFC, 0, 1, "R6");
        acc('h400, 0, 1, "R6");
        idle(4);
        acc('h000, 1, 0, "R6");
        // back-to-back hotspot reads reversed order
        acc('hFFB, 1, 0, "R4");
        acc('hFF6, 1, 0, "R4");
        acc('h800, 1, 0, "R1");
        // reset mid-run restores bank 5 (R2)
        idle(1);
        do_reset();
        exp_q.delete();
        acc('h000, 1, 0, "R2");
        idle(4);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++; $display("FAIL R7: %0d reads unanswered expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule